// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits on the root-complex side of a PCIe link and turns message-signalled interrupts back into a level interrupt for the host. It watches inbound posted memory writes, each given as a 64-bit address, a 32-bit data word and a valid strobe. When a write lands on the programmed 64-bit target address, the block uses the data payload as a vector number. If that vector is enabled, the block records the event in a per-vector status bit.

Vectors are arranged in eight groups of 32. Each group has an enable word, a mask word and a status word. Status bits that are set and not masked are combined into one interrupt output, which is registered. Software reaches the target address and all group registers through a simple 32-bit register port with combinational readback. Software clears status by writing ones.

The inbound stream uses a valid/ready handshake. The block never applies back-pressure: `in_ready` is high whenever reset is released, so every cycle with `in_valid` high is an accepted write. Upstream logic may present a new write on every cycle.

Top module: `msi_capture_ctrl`

## Requirements
- R1: Reset clears every enable word, every status word and both address words, sets every mask word to 0xFFFFFFFF, and drives `irq_out` low.
- R2: Register word map. Word 0 holds the target address bits [31:0] and word 1 holds bits [63:32]. For group g (0..7), word 2+3g is enable, word 3+3g is mask and word 4+3g is status. Enable, mask and address words read back what was written. Reads of any other word return 0, and writes to other words have no effect.
- R3: An accepted inbound write whose address equals {word 1, word 0} and whose data is below 256 sets status bit data[4:0] of group data[7:5], provided the matching enable bit is 1. The new value is readable after the accepting clock edge.
- R4: A matching inbound write to a vector whose enable bit is 0 leaves that status bit at 0.
- R5: An inbound write whose address differs from the target in either word, or whose data is 256 or more, changes no status bit.
- R6: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A status write never sets a bit.
- R7: When an inbound set and a software clear hit the same status bit on the same edge, the bit ends up set.
- R8: `irq_out` equals the OR over all groups of (status AND NOT mask), delayed by one clock. Changing a mask bit alone therefore raises or drops the output one edge later.
- R9: `in_ready` is always high, and inbound writes on consecutive cycles are each captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound write present |
| in_ready | output | 1 | Inbound write accepted (always high) |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number) |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 1 | Aggregated interrupt to host |

## Verification
Inbound writes are sent in several forms, each of which isolates one condition:
- Writes that hit an enabled vector.
- Writes that hit a disabled vector.
- Writes that are wrong in only the high or only the low address word.
- Writes whose data is just above the vector range, which would alias onto a valid bit if the decode were truncated.
- A burst of back-to-back writes, which shows whether any accepted write is dropped.

Status clears are tried with all-zero data, with a single bit, and on the same edge as an inbound set to the same vector; the last case shows which side wins. The interrupt output is observed while mask bits are toggled in two different groups, which separates the masking path from the capture path.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned VEC_PER_GRP = 32;
  localparam int unsigned HDR_WORDS   = 2;   // address low, address high
  localparam int unsigned FLD_PER_GRP = 3;   // enable, mask, status

  typedef enum logic [1:0] {
    FLD_EN   = 2'd0,
    FLD_MASK = 2'd1,
    FLD_STAT = 2'd2,
    FLD_NONE = 2'd3
  } grp_field_e;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned NGRP = 8,
  parameter int unsigned RAW  = 5
) (
  input  logic [RAW-1:0]  reg_addr,
  output logic            sel_lo,
  output logic            sel_hi,
  output logic [NGRP-1:0] grp_sel,
  output grp_field_e      fld
);
  logic [NGRP-1:0] hit_en, hit_mask, hit_stat;

  assign sel_lo = (reg_addr == RAW'(0));
  assign sel_hi = (reg_addr == RAW'(1));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned BASE = HDR_WORDS + FLD_PER_GRP * g;
    assign hit_en[g]   = (reg_addr == RAW'(BASE));
    assign hit_mask[g] = (reg_addr == RAW'(BASE + 1));
    assign hit_stat[g] = (reg_addr == RAW'(BASE + 2));
    assign grp_sel[g]  = hit_en[g] | hit_mask[g] | hit_stat[g];
  end

  always_comb begin
    if (|hit_en)        fld = FLD_EN;
    else if (|hit_mask) fld = FLD_MASK;
    else if (|hit_stat) fld = FLD_STAT;
    else                fld = FLD_NONE;
  end
endmodule

// File: rtl/msi_hit_decode.sv
module msi_hit_decode #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NVEC = 256
) (
  input  logic            in_valid,
  input  logic [2*DW-1:0] in_addr,
  input  logic [DW-1:0]   in_data,
  input  logic [2*DW-1:0] tgt_addr,
  output logic [NVEC-1:0] set_vec
);
  localparam int unsigned IDXW = $clog2(NVEC);

  logic            in_range;
  logic            hit;
  logic [IDXW-1:0] idx;

  assign in_range = (in_data[DW-1:IDXW] == '0);
  assign hit      = in_valid && (in_addr == tgt_addr) && in_range;
  assign idx      = in_data[IDXW-1:0];

  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    assign set_vec[i] = hit && (idx == IDXW'(i));
  end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group #(
  parameter int unsigned VEC = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_mask,
  input  logic           wr_stat,
  input  logic [VEC-1:0] wdata,
  input  logic [VEC-1:0] set_in,
  output logic [VEC-1:0] en_q,
  output logic [VEC-1:0] mask_q,
  output logic [VEC-1:0] stat_q,
  output logic           pend
);
  logic [VEC-1:0] clr;
  logic [VEC-1:0] set_ok;

  assign clr    = wr_stat ? wdata : '0;
  assign set_ok = set_in & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      // the inbound set is applied after the clear, so it wins
      stat_q <= (stat_q & ~clr) | set_ok;
    end
  end

  assign pend = |(stat_q & ~mask_q);
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg #(
  parameter int unsigned NGRP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] pend,
  output logic            irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int unsigned NGRP = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned RAW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2*DW-1:0] in_addr,
  input  logic [DW-1:0]   in_data,
  input  logic            reg_wen,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_out
);
  localparam int unsigned NVEC = NGRP * VEC_PER_GRP;

  logic [DW-1:0]     addr_lo_q, addr_hi_q;
  logic [2*DW-1:0]   tgt_addr;
  logic              sel_lo, sel_hi;
  logic [NGRP-1:0]   grp_sel;
  grp_field_e        fld;
  logic [NVEC-1:0]   set_vec;
  logic [NVEC-1:0]   en_flat, msk_flat, stat_flat;
  logic [NGRP-1:0]   pend;

  assign in_ready = 1'b1;
  assign tgt_addr = {addr_hi_q, addr_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
    end else if (reg_wen) begin
      if (sel_lo) addr_lo_q <= reg_wdata;
      if (sel_hi) addr_hi_q <= reg_wdata;
    end
  end

  msi_reg_decode #(.NGRP(NGRP), .RAW(RAW)) dec_i (
    .reg_addr (reg_addr),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .grp_sel  (grp_sel),
    .fld      (fld)
  );

  msi_hit_decode #(.DW(DW), .NVEC(NVEC)) hit_i (
    .in_valid (in_valid && in_ready),
    .in_addr  (in_addr),
    .in_data  (in_data),
    .tgt_addr (tgt_addr),
    .set_vec  (set_vec)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic wsel;
    assign wsel = reg_wen && grp_sel[g];
    msi_vec_group #(.VEC(VEC_PER_GRP)) grp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wsel && (fld == FLD_EN)),
      .wr_mask (wsel && (fld == FLD_MASK)),
      .wr_stat (wsel && (fld == FLD_STAT)),
      .wdata   (reg_wdata[VEC_PER_GRP-1:0]),
      .set_in  (set_vec[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .en_q    (en_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .mask_q  (msk_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .stat_q  (stat_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .pend    (pend[g])
    );
  end

  msi_irq_agg #(.NGRP(NGRP)) agg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .irq_q (irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_lo) reg_rdata = addr_lo_q;
    if (sel_hi) reg_rdata = addr_hi_q;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_sel[g]) begin
        case (fld)
          FLD_EN:   reg_rdata = DW'(en_flat[g*VEC_PER_GRP +: VEC_PER_GRP]);
          FLD_MASK: reg_rdata = DW'(msk_flat[g*VEC_PER_GRP +: VEC_PER_GRP]);
          FLD_STAT: reg_rdata = DW'(stat_flat[g*VEC_PER_GRP +: VEC_PER_GRP]);
          default:  reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int unsigned NVEC = 256,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2*DW-1:0] in_addr,
  input logic [DW-1:0]   in_data,
  input logic [2*DW-1:0] tgt,
  input logic [NVEC-1:0] en,
  input logic [NVEC-1:0] msk,
  input logic [NVEC-1:0] stat,
  input logic            irq_out
);
  localparam int unsigned IDXW = $clog2(NVEC);

  logic            hit;
  logic [IDXW-1:0] idx;
  assign hit = in_valid && (in_addr == tgt) && ((in_data >> IDXW) == '0);
  assign idx = in_data[IDXW-1:0];

  // R3: enabled hit sets its status bit
  a_r3_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && en[idx]) |=> stat[$past(idx)]);

  // R4: disabled vector stays clear
  a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !en[idx] && !stat[idx]) |=> !stat[$past(idx)]);

  // R5: a status bit only rises after a matching in-range write
  a_r5_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) != '0) |-> $past(hit));

  // R8: output follows pending with one cycle of delay
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(stat & ~msk)));

  // R9: no back-pressure
  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

bind msi_capture_ctrl msi_capture_chk #(.NVEC(NVEC), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_addr  (in_addr),
  .in_data  (in_data),
  .tgt      (tgt_addr),
  .en       (en_flat),
  .msk      (msk_flat),
  .stat     (stat_flat),
  .irq_out  (irq_out)
);

// File: tb/msi_capture_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_capture_ctrl_tb_top;
  localparam int NG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        reg_wen = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  always #10 clk = ~clk;

  msi_capture_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_en [NG];
  logic [31:0] m_msk[NG];
  logic [31:0] m_st [NG];
  logic [31:0] m_lo, m_hi;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  rd_item_t cur;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read result and compares it
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      check(reg_rdata, cur.exp, cur.tag);
    end
  end

  function automatic logic [31:0] exp_word(input int a);
    if (a == 0) return m_lo;
    if (a == 1) return m_hi;
    if (a >= 2 && a < 2 + 3*NG) begin
      case ((a - 2) % 3)
        0: return m_en[(a-2)/3];
        1: return m_msk[(a-2)/3];
        default: return m_st[(a-2)/3];
      endcase
    end
    return 32'h0;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int g = 0; g < NG; g++) r |= |(m_st[g] & ~m_msk[g]);
    return r;
  endfunction

  task automatic model_reg(input int a, input logic [31:0] d);
    if (a == 0) m_lo = d;
    else if (a == 1) m_hi = d;
    else if (a >= 2 && a < 2 + 3*NG) begin
      case ((a - 2) % 3)
        0: m_en[(a-2)/3] = d;
        1: m_msk[(a-2)/3] = d;
        default: m_st[(a-2)/3] &= ~d;
      endcase
    end
  endtask

  task automatic model_in(input logic [63:0] a, input logic [31:0] d);
    if (a == {m_hi, m_lo} && d < 256 && m_en[d >> 5][d[4:0]])
      m_st[d >> 5][d[4:0]] = 1'b1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    reg_wen = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic put_reg(input int a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    model_reg(a, d);
  endtask

  task automatic put_in(input logic [63:0] a, input logic [31:0] d);
    in_valid = 1'b1; in_addr = a; in_data = d;
    model_in(a, d);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1; put_reg(a, d); idle();
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    @(posedge clk); #1; put_in(a, d); idle();
  endtask

  task automatic rd(input int a, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    reg_addr = 5'(a);
    it.exp = exp_word(a); it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input string tag);
    @(posedge clk); @(negedge clk);
    check({31'b0, irq_out}, {31'b0, exp_irq()}, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_en[g] = '0; m_msk[g] = '1; m_st[g] = '0;
    end
    m_lo = '0; m_hi = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 2 + 3*NG; a++) rd(a, "R1 reset value");
    check({31'b0, irq_out}, 32'h0, "R1 irq low after reset");
    check({31'b0, in_ready}, 32'h1, "R9 ready after reset");

    // R2 register map
    wr(0, TGT[31:0]);
    wr(1, TGT[63:32]);
    rd(0, "R2 addr low");
    rd(1, "R2 addr high");
    wr(30, 32'hDEAD_BEEF);
    rd(30, "R2 unmapped word");
    wr(2, 32'hFFFF_FFFF);        // group 0 enable
    wr(11, 32'h0000_00F0);       // group 3 enable
    rd(2, "R2 enable g0");
    rd(11, "R2 enable g3");

    // R3 capture
    send(TGT, 32'd5);
    rd(4, "R3 g0 status bit5");
    send(TGT, 32'd100);          // group 3 bit 4
    rd(13, "R3 g3 status bit4");
    chk_irq("R8 masked stays low");

    // R4 disabled vector
    send(TGT, 32'd97);           // group 3 bit 1, not enabled
    rd(13, "R4 disabled vector");

    // R5 ignored writes
    send(TGT ^ 64'h1_0000_0000, 32'd6);
    send(TGT ^ 64'h10, 32'd7);
    send(TGT, 32'd256 + 32'd8);
    rd(4, "R5 mismatched addr or data");

    // R8 masking in group 0
    wr(3, ~32'h20);
    chk_irq("R8 unmask raises irq");
    wr(3, 32'hFFFF_FFFF);
    chk_irq("R8 mask drops irq");

    // R6 write-one-to-clear
    wr(4, 32'h0);
    rd(4, "R6 zero write keeps status");
    wr(4, 32'h20);
    rd(4, "R6 one clears bit");
    wr(4, 32'hFFFF_FFFF);
    rd(4, "R6 clear never sets");

    // R7 set wins over clear on the same edge
    send(TGT, 32'd9);
    @(posedge clk); #1;
    put_reg(4, 32'h200);
    put_in(TGT, 32'd9);
    idle();
    rd(4, "R7 set wins");

    // R9 back-to-back writes
    @(posedge clk); #1;
    put_in(TGT, 32'd12);
    @(posedge clk); #1;
    put_in(TGT, 32'd13);
    @(posedge clk); #1;
    check({31'b0, in_ready}, 32'h1, "R9 ready during burst");
    put_in(TGT, 32'd14);
    idle();
    rd(4, "R9 burst captured");

    // R8 second group path
    wr(12, ~32'h10);
    chk_irq("R8 g3 unmask raises irq");
    wr(13, 32'h10);
    rd(13, "R6 g3 clear");
    chk_irq("R8 clear drops irq");

    for (int a = 0; a < 2 + 3*NG; a++) rd(a, "R2 final readback");

    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule